// File: doc/BRIEF.md
# Parking fare payment controller

This block runs a car park pay station from a single fast system clock (50 MHz by default). A driver first sees an insert-ticket prompt. Inserting the ticket brings up a remove-ticket prompt, and removing it opens the payment stage. That stage shows the fare still owed, which starts at 1.50. Coins of 50, 20 and 10 pence are subtracted from the outstanding amount until nothing is left. The station then shows 0.00 for a short dwell and goes back to the first prompt.

All four push-button inputs are raw and asynchronous. Each one is synchronised and reduced to a one-cycle event, so a press held for millions of cycles still counts once. Nothing in the block runs on a divided clock. Each prompt stage, and the paid stage, stays on screen for a minimum dwell counted in system cycles before the next event is accepted. The outputs are a 2-bit stage code and four 4-bit digit values for a downstream seven-segment decoder.

Top module: `park_fare_ctrl`

## Requirements
- R1: While `rst_n` is low, and on its release, the stage code is 0, the display is 16'hAAAA and the internal amount owed is 150 pence.
- R2: A press is acted on at the third rising clock edge after the raw input is first sampled high. A press held for any length of time takes effect exactly once.
- R3: In the insert stage (code 0), a rising edge of `ticket_i` moves to the remove stage (code 1) only once the stage has lasted `DWELL_CYCLES` cycles. Earlier rising edges are dropped, not queued.
- R4: In the remove stage, a falling edge of `ticket_i` moves to the payment stage (code 2) only once the stage has lasted `DWELL_CYCLES` cycles. Earlier falling edges are dropped.
- R5: In the payment stage, one press of `coin50_i`, `coin20_i` or `coin10_i` lowers the amount owed by 50, 20 or 10 pence respectively.
- R6: A coin worth at least the amount owed sets the amount to zero, with no wrap, and moves to the paid stage (code 3). The payment stage never holds a zero amount.
- R7: The paid stage shows 16'h0000 for `DWELL_CYCLES` cycles, then returns to the insert stage with the amount reloaded to 150.
- R8: Coin presses have no effect outside the payment stage. Ticket edges have no effect inside the payment stage.
- R9: When coin events coincide, only one coin is taken, with priority 50 over 20 over 10.
- R10: The display nibbles [15:12],[11:8],[7:4],[3:0] read 4'hA each in the insert stage and 4'hB each in the remove stage. In the payment and paid stages they read 0, pounds, tens of pence and pence, all in BCD.
- R11: `stage_o` encodes 0 insert, 1 remove, 2 payment, 3 paid.
- R12: The stage only ever advances in the cyclic order 0, 1, 2, 3, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| coin50_i | input | 1 | Raw 50 pence coin button |
| coin20_i | input | 1 | Raw 20 pence coin button |
| coin10_i | input | 1 | Raw 10 pence coin button |
| ticket_i | input | 1 | Raw ticket-present input, high while a ticket is inserted |
| stage_o | output | 2 | Current stage code |
| disp_bcd_o | output | 16 | Four display digits, most significant nibble on the left |

## Verification
Several properties are checked on every cycle:
- the stage only advances in cyclic order;
- the amount is frozen during the prompt stages;
- each drop in the payment stage equals one coin value;
- the payment stage never shows zero owed;
- the paid stage always shows zeros;
- payment-stage digits are valid BCD.

Other behaviour only the bench scenarios can show, through a behavioural model compared every cycle:
- the three-edge press latency;
- single registration of a long hold;
- early ticket edges being dropped against the dwell;
- coin priority when presses coincide;
- clamping on overpayment;
- the fare being reloaded after the paid dwell.

// File: rtl/park_fare_pkg.sv
package park_fare_pkg;

  typedef enum logic [1:0] {
    ST_INSERT = 2'd0,
    ST_REMOVE = 2'd1,
    ST_DUE    = 2'd2,
    ST_PAID   = 2'd3
  } pay_stage_e;

  // Button positions inside the conditioned event vector
  localparam int unsigned BTN_C50   = 0;
  localparam int unsigned BTN_C20   = 1;
  localparam int unsigned BTN_C10   = 2;
  localparam int unsigned BTN_TKT   = 3;
  localparam int unsigned BTN_COUNT = 4;

  // Non-decimal nibbles the glyph decoder maps to prompt text
  localparam logic [3:0] GLYPH_INSERT = 4'hA;
  localparam logic [3:0] GLYPH_REMOVE = 4'hB;

endpackage

// File: rtl/pf_btn_edge.sv
module pf_btn_edge #(
  parameter int unsigned N        = 4,
  parameter int unsigned FALL_IDX = N - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] rise_o,
  output logic         fall_o
);

  logic [N-1:0] meta_q;
  logic [N-1:0] sync_q;
  logic [N-1:0] prev_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_btn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q[i] <= 1'b0;
          sync_q[i] <= 1'b0;
          prev_q[i] <= 1'b0;
        end else begin
          meta_q[i] <= raw_i[i];
          sync_q[i] <= meta_q[i];
          prev_q[i] <= sync_q[i];
        end
      end
      assign rise_o[i] = sync_q[i] & ~prev_q[i];
    end
  endgenerate

  assign fall_o = prev_q[FALL_IDX] & ~sync_q[FALL_IDX];

endmodule

// File: rtl/pf_bcd_conv.sv
module pf_bcd_conv #(
  parameter int unsigned BIN_W  = 8,
  parameter int unsigned DIGITS = 3
) (
  input  logic [BIN_W-1:0]    bin_i,
  output logic [4*DIGITS-1:0] bcd_o
);

  localparam int unsigned SH_W = 4 * DIGITS + BIN_W;

  logic [SH_W-1:0] sh;

  // Shift-and-add-three conversion, fully combinational
  always_comb begin
    sh = '0;
    sh[BIN_W-1:0] = bin_i;
    for (int b = 0; b < BIN_W; b++) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (sh[BIN_W + 4*d +: 4] >= 4'd5) begin
          sh[BIN_W + 4*d +: 4] = sh[BIN_W + 4*d +: 4] + 4'd3;
        end
      end
      sh = sh << 1;
    end
    bcd_o = sh[BIN_W +: 4*DIGITS];
  end

endmodule

// File: rtl/pf_pay_seq.sv
module pf_pay_seq
  import park_fare_pkg::*;
#(
  parameter int unsigned FARE_PENCE   = 150,
  parameter int unsigned DWELL_CYCLES = 50_000_000,
  parameter int unsigned COIN_HI      = 50,
  parameter int unsigned COIN_MID     = 20,
  parameter int unsigned COIN_LO      = 10,
  localparam int unsigned AMT_W       = $clog2(FARE_PENCE + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BTN_COUNT-1:0] rise_i,
  input  logic                 tkt_fall_i,
  output pay_stage_e           stage_o,
  output logic [AMT_W-1:0]     amount_o
);

  localparam int unsigned CNT_W  = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] DONE_V = CNT_W'(DWELL_CYCLES - 1);
  localparam logic [AMT_W-1:0] FARE_V = AMT_W'(FARE_PENCE);
  localparam logic [AMT_W-1:0] HI_V   = AMT_W'(COIN_HI);
  localparam logic [AMT_W-1:0] MID_V  = AMT_W'(COIN_MID);
  localparam logic [AMT_W-1:0] LO_V   = AMT_W'(COIN_LO);

  pay_stage_e       stage_q, stage_d;
  logic [AMT_W-1:0] amount_q, amount_d;
  logic [CNT_W-1:0] dwell_q, dwell_d;
  logic             dwell_done;
  logic             dwell_en;
  logic             amount_en;
  logic             coin_hit;
  logic [AMT_W-1:0] coin_val;

  assign dwell_done = (dwell_q == DONE_V);

  // Fixed priority: highest coin value wins
  always_comb begin
    coin_hit = 1'b1;
    coin_val = '0;
    if (rise_i[BTN_C50]) begin
      coin_val = HI_V;
    end else if (rise_i[BTN_C20]) begin
      coin_val = MID_V;
    end else if (rise_i[BTN_C10]) begin
      coin_val = LO_V;
    end else begin
      coin_hit = 1'b0;
    end
  end

  always_comb begin
    stage_d  = stage_q;
    amount_d = amount_q;
    unique case (stage_q)
      ST_INSERT: begin
        if (dwell_done && rise_i[BTN_TKT]) stage_d = ST_REMOVE;
      end
      ST_REMOVE: begin
        if (dwell_done && tkt_fall_i) stage_d = ST_DUE;
      end
      ST_DUE: begin
        if (coin_hit) begin
          if (coin_val >= amount_q) begin
            amount_d = '0;
            stage_d  = ST_PAID;
          end else begin
            amount_d = amount_q - coin_val;
          end
        end
      end
      ST_PAID: begin
        if (dwell_done) begin
          stage_d  = ST_INSERT;
          amount_d = FARE_V;
        end
      end
      default: stage_d = ST_INSERT;
    endcase
  end

  assign amount_en = (amount_d != amount_q);

  // Dwell counter restarts on every stage change and saturates
  always_comb begin
    dwell_en = 1'b1;
    if (stage_d != stage_q) begin
      dwell_d = '0;
    end else if (!dwell_done) begin
      dwell_d = dwell_q + 1'b1;
    end else begin
      dwell_d  = dwell_q;
      dwell_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_INSERT;
    end else begin
      stage_q <= stage_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amount_q <= FARE_V;
    end else if (amount_en) begin
      amount_q <= amount_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwell_q <= '0;
    end else if (dwell_en) begin
      dwell_q <= dwell_d;
    end
  end

  assign stage_o  = stage_q;
  assign amount_o = amount_q;

endmodule

// File: rtl/park_fare_ctrl.sv
module park_fare_ctrl
  import park_fare_pkg::*;
#(
  parameter int unsigned FARE_PENCE   = 150,
  parameter int unsigned DWELL_CYCLES = 50_000_000,
  parameter int unsigned COIN_HI      = 50,
  parameter int unsigned COIN_MID     = 20,
  parameter int unsigned COIN_LO      = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        coin50_i,
  input  logic        coin20_i,
  input  logic        coin10_i,
  input  logic        ticket_i,
  output logic [1:0]  stage_o,
  output logic [15:0] disp_bcd_o
);

  localparam int unsigned AMT_W    = $clog2(FARE_PENCE + 1);
  localparam int unsigned AMT_DIGS = 3;

  logic [BTN_COUNT-1:0]  raw_w;
  logic [BTN_COUNT-1:0]  rise_w;
  logic                  tkt_fall_w;
  pay_stage_e            stage_w;
  logic [AMT_W-1:0]      amount_w;
  logic [4*AMT_DIGS-1:0] bcd_w;

  always_comb begin
    raw_w          = '0;
    raw_w[BTN_C50] = coin50_i;
    raw_w[BTN_C20] = coin20_i;
    raw_w[BTN_C10] = coin10_i;
    raw_w[BTN_TKT] = ticket_i;
  end

  pf_btn_edge #(
    .N        (BTN_COUNT),
    .FALL_IDX (BTN_TKT)
  ) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (raw_w),
    .rise_o (rise_w),
    .fall_o (tkt_fall_w)
  );

  pf_pay_seq #(
    .FARE_PENCE   (FARE_PENCE),
    .DWELL_CYCLES (DWELL_CYCLES),
    .COIN_HI      (COIN_HI),
    .COIN_MID     (COIN_MID),
    .COIN_LO      (COIN_LO)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (rise_w),
    .tkt_fall_i (tkt_fall_w),
    .stage_o    (stage_w),
    .amount_o   (amount_w)
  );

  pf_bcd_conv #(
    .BIN_W  (AMT_W),
    .DIGITS (AMT_DIGS)
  ) u_bcd (
    .bin_i (amount_w),
    .bcd_o (bcd_w)
  );

  always_comb begin
    unique case (stage_w)
      ST_INSERT: disp_bcd_o = {4{GLYPH_INSERT}};
      ST_REMOVE: disp_bcd_o = {4{GLYPH_REMOVE}};
      default:   disp_bcd_o = {4'h0, bcd_w};
    endcase
  end

  assign stage_o = stage_w;

endmodule

// File: rtl/park_fare_ctrl_chk.sv
module park_fare_ctrl_chk
  import park_fare_pkg::*;
#(
  parameter int unsigned FARE_PENCE = 150,
  parameter int unsigned COIN_HI    = 50,
  parameter int unsigned COIN_MID   = 20,
  parameter int unsigned COIN_LO    = 10,
  localparam int unsigned AMT_W     = $clog2(FARE_PENCE + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       stage,
  input logic [15:0]      disp,
  input logic [AMT_W-1:0] amount
);

  localparam logic [AMT_W-1:0] FARE_V = AMT_W'(FARE_PENCE);
  localparam logic [AMT_W-1:0] HI_V   = AMT_W'(COIN_HI);
  localparam logic [AMT_W-1:0] MID_V  = AMT_W'(COIN_MID);
  localparam logic [AMT_W-1:0] LO_V   = AMT_W'(COIN_LO);

  AST_STAGE_CYCLIC: assert property (@(posedge clk) disable iff (!rst_n)
    (stage != $past(stage)) |-> (stage == 2'($past(stage) + 2'd1))); // R12

  AST_PROMPT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stage) == ST_INSERT || $past(stage) == ST_REMOVE) |-> $stable(amount)); // R8

  AST_ONE_COIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stage) == ST_DUE && stage == ST_DUE && amount != $past(amount)) |->
    (($past(amount) - amount) == HI_V || ($past(amount) - amount) == MID_V ||
     ($past(amount) - amount) == LO_V)); // R5

  AST_DUE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_DUE) |-> (amount != '0)); // R6

  AST_PAID_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_PAID) |-> (disp == 16'h0000 && amount == '0)); // R7

  AST_INSERT_FULL_FARE: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_INSERT) |-> (amount == FARE_V)); // R7

  AST_DUE_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_DUE) |-> (disp[15:12] == 4'd0 && disp[11:8] <= 4'd9 &&
                           disp[7:4] <= 4'd9 && disp[3:0] <= 4'd9)); // R10

endmodule

bind park_fare_ctrl park_fare_ctrl_chk #(
  .FARE_PENCE (FARE_PENCE),
  .COIN_HI    (COIN_HI),
  .COIN_MID   (COIN_MID),
  .COIN_LO    (COIN_LO)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .stage  (stage_o),
  .disp   (disp_bcd_o),
  .amount (amount_w)
);

// File: tb/park_fare_ctrl_tb_top.sv
module park_fare_ctrl_tb_top;

  localparam int DW   = 16;
  localparam int FARE = 150;

  logic        clk;
  logic        rst_n;
  logic [3:0]  btn;   // [0]=50p [1]=20p [2]=10p [3]=ticket
  logic [1:0]  stage;
  logic [15:0] disp;

  int tests;
  int fails;
  bit done;

  park_fare_ctrl #(.DWELL_CYCLES(DW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .coin50_i   (btn[0]),
    .coin20_i   (btn[1]),
    .coin10_i   (btn[2]),
    .ticket_i   (btn[3]),
    .stage_o    (stage),
    .disp_bcd_o (disp)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         m_stage, m_amt, m_cnt, n_stage, n_amt, coin;
  bit         m_done;
  logic [3:0] hist[$];
  logic [3:0] rise;
  logic       tfall;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stage = 0; m_amt = FARE; m_cnt = 0;
      hist = '{4'b0, 4'b0, 4'b0};
    end else begin
      rise   = hist[1] & ~hist[0];
      tfall  = hist[0][3] & ~hist[1][3];
      m_done = (m_cnt == DW - 1);
      n_stage = m_stage; n_amt = m_amt;
      coin = rise[0] ? 50 : rise[1] ? 20 : rise[2] ? 10 : 0;
      case (m_stage)
        0: if (m_done && rise[3]) n_stage = 1;
        1: if (m_done && tfall) n_stage = 2;
        2: if (coin != 0) begin
             if (coin >= m_amt) begin n_amt = 0; n_stage = 3; end
             else n_amt = m_amt - coin;
           end
        default: if (m_done) begin n_stage = 0; n_amt = FARE; end
      endcase
      if (n_stage != m_stage) m_cnt = 0;
      else if (!m_done) m_cnt++;
      m_stage = n_stage; m_amt = n_amt;
      void'(hist.pop_front());
      hist.push_back(btn);
    end
  end

  function automatic logic [15:0] exp_disp(int st, int amt);
    if (st == 0) return 16'hAAAA;
    if (st == 1) return 16'hBBBB;
    return {4'h0, 4'(amt / 100), 4'((amt / 10) % 10), 4'(amt % 10)};
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R11 stage vs model", 32'(stage), 32'(m_stage));
      check("R10 display vs model", 32'(disp), 32'(exp_disp(m_stage, m_amt)));
    end
  end

  // ---------------- helpers ----------------
  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(int idx, int hold);
    btn[idx] = 1'b1;
    waitn(hold);
    btn[idx] = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- directed scenario ----------------
  initial begin
    tests = 0; fails = 0; done = 0;
    btn = 4'b0; rst_n = 1'b0;
    waitn(3);
    check("R1 reset stage", 32'(stage), 32'd0);
    check("R1 reset display", 32'(disp), 32'hAAAA);
    rst_n = 1'b1;

    // R3: early ticket insertion dropped; R8: coin in insert stage ignored
    btn[3] = 1'b1;
    waitn(5);
    press(0, 4);
    waitn(21);
    check("R3 early insert dropped", 32'(stage), 32'd0);
    btn[3] = 1'b0;
    waitn(4);
    btn[3] = 1'b1;
    waitn(5);
    check("R3 insert accepted after dwell", 32'(stage), 32'd1);
    check("R10 remove prompt glyphs", 32'(disp), 32'hBBBB);

    // R4: early removal dropped
    btn[3] = 1'b0;
    waitn(10);
    press(2, 3);
    waitn(15);
    check("R4 early removal dropped", 32'(stage), 32'd1);
    btn[3] = 1'b1;
    waitn(5);
    btn[3] = 1'b0;
    waitn(5);
    check("R4 removal enters payment", 32'(stage), 32'd2);
    check("R8 prompt coins left fare intact", 32'(disp), 32'h0150);

    // R2: three-edge latency and single registration of a long hold
    btn[0] = 1'b1;
    waitn(1);
    check("R2 no change after edge 1", 32'(disp), 32'h0150);
    waitn(1);
    check("R2 no change after edge 2", 32'(disp), 32'h0150);
    waitn(1);
    check("R2 deducted at edge 3", 32'(disp), 32'h0100);
    waitn(40);
    check("R2 long hold counted once", 32'(disp), 32'h0100);
    btn[0] = 1'b0;
    waitn(4);

    // R5: 20p and 10p
    press(1, 3); waitn(5);
    check("R5 20p deducted", 32'(disp), 32'h0080);
    press(2, 3); waitn(5);
    check("R5 10p deducted", 32'(disp), 32'h0070);

    // R8: ticket ignored in payment stage
    btn[3] = 1'b1; waitn(5); btn[3] = 1'b0; waitn(6);
    check("R8 ticket ignored stage", 32'(stage), 32'd2);
    check("R8 ticket ignored amount", 32'(disp), 32'h0070);

    // R9: simultaneous coins -> only 50p
    btn[2:0] = 3'b111; waitn(3); btn[2:0] = 3'b000; waitn(5);
    check("R9 priority 50p only", 32'(disp), 32'h0020);

    // R6: overpayment clamps to zero
    press(0, 2); waitn(3);
    check("R6 clamp enters paid", 32'(stage), 32'd3);
    check("R7 paid display zeros", 32'(disp), 32'h0000);
    press(2, 2);
    waitn(4);
    check("R7 paid held during dwell", 32'(stage), 32'd3);
    waitn(20);
    check("R7 return to insert", 32'(stage), 32'd0);
    check("R12 wrap to insert glyphs", 32'(disp), 32'hAAAA);

    // R7: fare reloaded
    waitn(20);
    btn[3] = 1'b1; waitn(20);
    btn[3] = 1'b0; waitn(6);
    check("R7 fare reloaded", 32'(disp), 32'h0150);

    // R6: exact payment
    press(0, 2); waitn(4);
    press(0, 2); waitn(4);
    check("R5 two 50p", 32'(disp), 32'h0050);
    press(0, 2); waitn(4);
    check("R6 exact payment paid", 32'(stage), 32'd3);
    waitn(25);
    check("R12 cyclic return", 32'(stage), 32'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule